// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is a clocked model of the command front end of a byte-wide NOR flash. Each bus write arrives as a single-cycle `wr_en` pulse carrying a 17-bit address and a data byte. The block follows the multi-write unlock-and-command protocol. When a sequence completes, it raises exactly one strobe for one cycle: return-to-read, byte program (with the target address and data), whole-array erase, or erase of one sector (with its 3-bit sector number).

Any write that breaks the expected pattern drops the decoder back to its idle (read) state, and no strobe is issued. While the downstream program or erase engine reports `busy`, writes are not decoded and the sequence position is held. A low-supply indication forces the idle state and blocks all writes. The array and the program and erase engines sit outside this block. They consume the strobes.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, every strobe output is 0 and the decoder is idle, so a full command sequence is accepted with no prior read/reset command.
- R2: The writes AAh@5555h, 55h@2AAAh, F0h@5555h raise `rd_reset_stb` for exactly one cycle. The strobe appears in the cycle after the last write. An F0h write at any other command address issues no strobe.
- R3: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, followed by one write of any address and data, raise `prog_stb` for one cycle. In that cycle `prog_addr` and `prog_data` equal the fourth write's full 17-bit address and its data byte.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h raise `chip_erase_stb` for one cycle.
- R5: The same first five writes as R4, followed by 30h at any address, raise `sector_erase_stb` for one cycle, with `sector_num` equal to that write's address bits [16:14].
- R6: Command addresses are matched on bits [14:0] only. A15 and A16 may take any value in every unlock write and every command write.
- R7: A write whose address or data does not match the current step returns the decoder to idle without a strobe. After that, a complete new sequence is needed.
- R8: While `busy` is 1, writes cause no strobe and leave the sequence position unchanged, so a sequence can resume after `busy` falls.
- R9: While `low_vcc` is 1, writes cause no strobe, and the decoder is forced to idle so that any partial sequence is discarded.
- R10: At most one strobe is high in any cycle, and no strobe is high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle bus write qualifier |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| busy | input | 1 | Embedded operation running; suspends decoding |
| low_vcc | input | 1 | Supply below lockout; forces idle and blocks writes |
| rd_reset_stb | output | 1 | Return-to-read command seen |
| prog_stb | output | 1 | Byte program command seen |
| prog_addr | output | 17 | Program target address, valid with `prog_stb` |
| prog_data | output | 8 | Program data, valid with `prog_stb` |
| chip_erase_stb | output | 1 | Whole-array erase command seen |
| sector_erase_stb | output | 1 | Sector erase command seen |
| sector_num | output | 3 | Sector to erase, valid with `sector_erase_stb` |

## Verification
A corrupted sequence position is only visible through the strobes. Either a strobe goes missing at the end of a correct sequence, or a strobe appears after a broken or suspended one. In both cases the symptom shows up one cycle after the final write of the affected sequence. A decoder that forgets to go idle after a mismatch lets a later partial sequence fire early. A decoder that clears its state while `busy` is high loses a sequence that should resume. The scenarios therefore end each disturbed sequence with the writes that would complete it under the faulty behaviour.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int MATCH_W   = 15,
  parameter int SECT_W    = 3,
  parameter logic [MATCH_W-1:0] KEY_ADDR_A = 15'h5555,
  parameter logic [MATCH_W-1:0] KEY_ADDR_B = 15'h2AAA,
  parameter logic [DW-1:0] KEY_A      = 8'hAA,
  parameter logic [DW-1:0] KEY_B      = 8'h55,
  parameter logic [DW-1:0] OP_READ    = 8'hF0,
  parameter logic [DW-1:0] OP_PROG    = 8'hA0,
  parameter logic [DW-1:0] OP_ERASE   = 8'h80,
  parameter logic [DW-1:0] OP_CHIP    = 8'h10,
  parameter logic [DW-1:0] OP_SECTOR  = 8'h30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              busy,
  input  logic              low_vcc,
  output logic              rd_reset_stb,
  output logic              prog_stb,
  output logic [AW-1:0]     prog_addr,
  output logic [DW-1:0]     prog_data,
  output logic              chip_erase_stb,
  output logic              sector_erase_stb,
  output logic [SECT_W-1:0] sector_num
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_ERA1, ST_ERA2, ST_ERA3
  } step_t;

  step_t step_q, step_d;
  logic  rd_d, prog_d, chip_d, sect_d;

  wire take  = wr_en & ~busy & ~low_vcc;
  wire at_a  = (wr_addr[MATCH_W-1:0] == KEY_ADDR_A);
  wire at_b  = (wr_addr[MATCH_W-1:0] == KEY_ADDR_B);
  wire key_a = at_a && (wr_data == KEY_A);
  wire key_b = at_b && (wr_data == KEY_B);

  always_comb begin
    step_d = step_q;
    rd_d   = 1'b0;
    prog_d = 1'b0;
    chip_d = 1'b0;
    sect_d = 1'b0;
    if (low_vcc) begin
      step_d = ST_IDLE;
    end else if (take) begin
      step_d = ST_IDLE;
      unique case (step_q)
        ST_IDLE: if (key_a) step_d = ST_KEY1;
        ST_KEY1: if (key_b) step_d = ST_KEY2;
        ST_KEY2: if (at_a) begin
          if (wr_data == OP_READ)       rd_d   = 1'b1;
          else if (wr_data == OP_PROG)  step_d = ST_PROG;
          else if (wr_data == OP_ERASE) step_d = ST_ERA1;
        end
        ST_PROG: prog_d = 1'b1;
        ST_ERA1: if (key_a) step_d = ST_ERA2;
        ST_ERA2: if (key_b) step_d = ST_ERA3;
        ST_ERA3: begin
          if (at_a && wr_data == OP_CHIP) chip_d = 1'b1;
          else if (wr_data == OP_SECTOR)  sect_d = 1'b1;
        end
        default: step_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q           <= ST_IDLE;
      rd_reset_stb     <= 1'b0;
      prog_stb         <= 1'b0;
      chip_erase_stb   <= 1'b0;
      sector_erase_stb <= 1'b0;
      prog_addr        <= '0;
      prog_data        <= '0;
      sector_num       <= '0;
    end else begin
      step_q           <= step_d;
      rd_reset_stb     <= rd_d;
      prog_stb         <= prog_d;
      chip_erase_stb   <= chip_d;
      sector_erase_stb <= sect_d;
      if (prog_d) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (sect_d) sector_num <= wr_addr[AW-1 -: SECT_W];
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic busy,
  input logic low_vcc,
  input logic rd_reset_stb,
  input logic prog_stb,
  input logic chip_erase_stb,
  input logic sector_erase_stb
);
  wire [3:0] stbs = {rd_reset_stb, prog_stb, chip_erase_stb, sector_erase_stb};

  // R10
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(stbs));

  // R10
  strobe_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stbs != 4'b0) |=> (stbs == 4'b0));

  // R8
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (stbs == 4'b0));

  // R9
  lowvcc_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_vcc |=> (stbs == 4'b0));

  // R3
  strobe_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (stbs == 4'b0));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(busy), .low_vcc(low_vcc),
  .rd_reset_stb(rd_reset_stb), .prog_stb(prog_stb),
  .chip_erase_stb(chip_erase_stb), .sector_erase_stb(sector_erase_stb)
);

// File: tb/flash_cmd_seq_tb.sv
module flash_cmd_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        busy = 1'b0;
  logic        low_vcc = 1'b0;
  logic        rd_reset_stb, prog_stb, chip_erase_stb, sector_erase_stb;
  logic [16:0] prog_addr;
  logic [7:0]  prog_data;
  logic [2:0]  sector_num;

  int total = 0, bad = 0;
  int n_rd = 0, n_pg = 0, n_ce = 0, n_se = 0, n_multi = 0;
  logic [16:0] last_pa;
  logic [7:0]  last_pd;
  logic [2:0]  last_sn;

  always #2.5 clk = ~clk;

  flash_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .low_vcc(low_vcc), .rd_reset_stb(rd_reset_stb), .prog_stb(prog_stb),
    .prog_addr(prog_addr), .prog_data(prog_data), .chip_erase_stb(chip_erase_stb),
    .sector_erase_stb(sector_erase_stb), .sector_num(sector_num)
  );

  always @(negedge clk) if (rst_n) begin
    n_rd += int'(rd_reset_stb);
    n_ce += int'(chip_erase_stb);
    if (prog_stb) begin n_pg++; last_pa = prog_addr; last_pd = prog_data; end
    if (sector_erase_stb) begin n_se++; last_sn = sector_num; end
    if ((int'(rd_reset_stb) + int'(prog_stb) + int'(chip_erase_stb) + int'(sector_erase_stb)) > 1)
      n_multi++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [16:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic unlock();
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55);
  endtask

  task automatic t_reset();
    check({rd_reset_stb, prog_stb, chip_erase_stb, sector_erase_stb} == 4'b0,
          "R1 strobes after reset", {rd_reset_stb, prog_stb, chip_erase_stb, sector_erase_stb}, 0);
  endtask

  task automatic t_program();
    int p0 = n_pg;
    unlock(); wr(17'h05555, 8'hA0); wr(17'h1ABCD, 8'h5A);
    settle();
    check(n_pg == p0 + 1, "R1 R3 program strobe count", n_pg - p0, 1);
    check(last_pa == 17'h1ABCD, "R3 program address", last_pa, 17'h1ABCD);
    check(last_pd == 8'h5A, "R3 program data", last_pd, 8'h5A);
  endtask

  task automatic t_read_reset();
    int r0 = n_rd;
    unlock(); wr(17'h05555, 8'hF0); settle();
    check(n_rd == r0 + 1, "R2 read/reset strobe", n_rd - r0, 1);
    unlock(); wr(17'h01234, 8'hF0); settle();
    check(n_rd == r0 + 1, "R2 F0 at wrong address", n_rd - r0, 1);
  endtask

  task automatic t_chip();
    int c0 = n_ce, s0 = n_se;
    unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h05555, 8'h10); settle();
    check(n_ce == c0 + 1, "R4 chip erase strobe", n_ce - c0, 1);
    check(n_se == s0, "R4 no sector strobe", n_se - s0, 0);
  endtask

  task automatic t_sector(input logic [16:0] a, input logic [2:0] exp_sn);
    int s0 = n_se;
    unlock(); wr(17'h05555, 8'h80); unlock(); wr(a, 8'h30); settle();
    check(n_se == s0 + 1, "R5 sector erase strobe", n_se - s0, 1);
    check(last_sn == exp_sn, "R5 sector number", last_sn, exp_sn);
  endtask

  task automatic t_dont_care();
    int p0 = n_pg, c0 = n_ce;
    wr(17'h1D555, 8'hAA); wr(17'h1AAAA, 8'h55); wr(17'h0D555, 8'hA0); wr(17'h00042, 8'hC3);
    settle();
    check(n_pg == p0 + 1, "R6 program with A15/A16 set", n_pg - p0, 1);
    wr(17'h15555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h1D555, 8'h80);
    wr(17'h0D555, 8'hAA); wr(17'h12AAA, 8'h55); wr(17'h1D555, 8'h10); settle();
    check(n_ce == c0 + 1, "R6 chip erase with A15/A16 set", n_ce - c0, 1);
  endtask

  task automatic t_abort();
    int p0 = n_pg, c0 = n_ce, s0 = n_se;
    wr(17'h05555, 8'hAA); wr(17'h02AAB, 8'h55); wr(17'h05555, 8'hA0); wr(17'h00100, 8'h11);
    settle();
    check(n_pg == p0, "R7 bad second address aborts", n_pg - p0, 0);
    wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h54); wr(17'h05555, 8'hA0); wr(17'h00100, 8'h11);
    settle();
    check(n_pg == p0, "R7 bad second data aborts", n_pg - p0, 0);
    unlock(); wr(17'h05555, 8'h80); wr(17'h05555, 8'h10); wr(17'h02AAA, 8'h55);
    wr(17'h05555, 8'h10); settle();
    check(n_ce == c0 && n_se == s0, "R7 erase without second unlock aborts", n_ce - c0, 0);
    unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h04000, 8'h31); settle();
    check(n_se == s0, "R7 bad final opcode aborts", n_se - s0, 0);
    unlock(); wr(17'h05555, 8'h80); unlock(); wr(17'h05555, 8'h10); settle();
    check(n_ce == c0 + 1, "R7 recovery after abort", n_ce - c0, 1);
  endtask

  task automatic t_busy();
    int p0 = n_pg;
    busy = 1'b1;
    unlock(); wr(17'h05555, 8'hA0); wr(17'h00200, 8'h22); settle();
    busy = 1'b0;
    check(n_pg == p0, "R8 busy blocks program", n_pg - p0, 0);
    unlock();
    busy = 1'b1; wr(17'h01111, 8'h99); wr(17'h05555, 8'hF0); busy = 1'b0;
    wr(17'h05555, 8'hA0); wr(17'h00300, 8'h33); settle();
    check(n_pg == p0 + 1, "R8 sequence resumes after busy", n_pg - p0, 1);
    check(last_pa == 17'h00300, "R8 resumed program address", last_pa, 17'h00300);
  endtask

  task automatic t_low_vcc();
    int p0 = n_pg;
    low_vcc = 1'b1;
    unlock(); wr(17'h05555, 8'hA0); wr(17'h00400, 8'h44); settle();
    low_vcc = 1'b0;
    check(n_pg == p0, "R9 low supply blocks writes", n_pg - p0, 0);
    unlock();
    @(negedge clk); low_vcc = 1'b1; @(negedge clk); low_vcc = 1'b0;
    wr(17'h05555, 8'hA0); wr(17'h00500, 8'h55); settle();
    check(n_pg == p0, "R9 low supply discards partial sequence", n_pg - p0, 0);
  endtask

  initial begin : watchdog
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_read_reset();
    t_chip();
    t_sector(17'h1C123, 3'd7);
    t_sector(17'h04000, 3'd1);
    t_sector(17'h0BFFF, 3'd2);
    t_dont_care();
    t_abort();
    t_busy();
    t_low_vcc();
    check(n_multi == 0, "R10 strobes exclusive", n_multi, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule